// File: doc/BRIEF.md
# Temperature and Humidity Sensor I2C Target Emulator

This block is a synthesizable I2C target that answers a bus master the way a digital temperature and humidity sensor does in single-shot mode. It watches SCL and SDA through its inputs and drives SDA only by pulling it low, so it sits on an open-drain bus. It recognises a 7-bit address whose lowest bit comes from a strap pin. It ACKs a two-byte measurement command. After a fixed conversion time it hands back two 16-bit words from its input ports, and each word is followed by a CRC byte.

The block does no sensing of its own. The words come from the `temp_i` and `humi_i` ports and are captured when the conversion time runs out. The block stands in for the real sensor when an I2C master is being tested. It covers the normal flow, a read that arrives too early, a read with no result waiting, a master that NACKs partway through, and a master addressing a device that is not on the bus.

Top module: `rht_i2c_target`

## Requirements
- R1: The 7-bit address is 0x44 when `addr_sel_i` is 0 and 0x45 when it is 1. The address byte on the wire is the address shifted left by one, with R/W in bit 0 (1 = read). Any other address is never ACKed and SDA stays released, so a master reading from it sees 0xFF in every byte.
- R2: In a write frame with a matching address, the target ACKs the address byte and every command byte that follows.
- R3: A measurement starts only when the write frame carries exactly the command bytes 0x2C then 0x06 and ends with STOP. Any other command is ACKed byte by byte but starts no measurement.
- R4: A read header that arrives fewer than `CONV_CYCLES` clocks after the command STOP is NACKed. Once that time has passed, the read header is ACKed.
- R5: The read returns six bytes, each MSB first, in this order: temperature high, temperature low, CRC of temperature, humidity high, humidity low, CRC of humidity.
- R6: Each CRC byte is CRC-8 over its two data bytes, high byte first. It uses polynomial 0x31 and initial value 0xFF, with no reflection and no final XOR. For the word 0xBEEF the CRC is 0x92.
- R7: If the master NACKs any byte, the target stops sending. SDA stays released for all further clocks until the next START or STOP.
- R8: A read header ACK consumes the result. A later read with no new measurement is NACKed.
- R9: The data words are captured from `temp_i` and `humi_i` when the conversion time runs out. Later changes on those inputs do not alter the bytes read back.
- R10: The target changes `sda_pull_o` only while SCL is low, and it only ever pulls SDA low.
- R11: After reset SDA is released and no result is pending.
- R12: A result stays available for any gap between the command frame and the read frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 10 times the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL level seen on the bus |
| sda_i | input | 1 | SDA level seen on the bus |
| sda_pull_o | output | 1 | 1 pulls SDA low; 0 releases it |
| addr_sel_i | input | 1 | Static strap that gives address bit 0 |
| temp_i | input | 16 | Temperature word to report |
| humi_i | input | 16 | Humidity word to report |

## Verification
The first symptom of a corrupted byte index or shift register is a wrong byte in the six-byte read. That byte is visible on the very next read, and the byte's position points to the faulty stage. A stuck conversion timer or pending flag shows up as the wrong ACK or NACK on the read header. A flag that clears when it should not shows up the same way on the read that follows. A control path that moves SDA while SCL is high causes a false START or STOP on the bus within the same bit. The bench watches `sda_pull_o` against its own SCL to catch that case.

// File: rtl/rht_pkg.sv
package rht_pkg;
  localparam int WORD_W = 16;
  localparam logic [7:0] CRC_POLY = 8'h31;
  localparam logic [7:0] CRC_SEED = 8'hFF;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_RX, ST_WACK, ST_TX, ST_MACK, ST_HOLD
  } tgt_state_t;

  // bit-serial CRC-8, MSB of the word first
  function automatic logic [7:0] crc8_word(input logic [WORD_W-1:0] w);
    logic [7:0] c;
    c = CRC_SEED;
    for (int i = WORD_W - 1; i >= 0; i--) begin
      c = (c[7] ^ w[i]) ? ({c[6:0], 1'b0} ^ CRC_POLY) : {c[6:0], 1'b0};
    end
    return c;
  endfunction
endpackage

// File: rtl/rht_bus_sync.sv
module rht_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_q,
  output logic sda_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_d    <= scl_pipe[STAGES-1];
      sda_d    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_q     = scl_pipe[STAGES-1];
  assign sda_q     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_q & ~scl_d;
  assign scl_fall  = ~scl_q & scl_d;
  assign bus_start = scl_q & scl_d & sda_d & ~sda_q;
  assign bus_stop  = scl_q & scl_d & ~sda_d & sda_q;
endmodule

// File: rtl/rht_conv_timer.sv
module rht_conv_timer #(
  parameter int CONV_CYCLES = 3000
) (
  input  logic clk,
  input  logic rst,
  input  logic kick,
  input  logic take,
  output logic ready,
  output logic done
);
  localparam int CW = $clog2(CONV_CYCLES + 1);
  logic [CW-1:0] cnt;
  logic busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      ready <= 1'b0;
      done  <= 1'b0;
      cnt   <= '0;
    end else begin
      done <= 1'b0;
      if (kick) begin
        busy  <= 1'b1;
        ready <= 1'b0;
        cnt   <= CW'(CONV_CYCLES - 1);
      end else if (busy) begin
        if (cnt == '0) begin
          busy  <= 1'b0;
          ready <= 1'b1;
          done  <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end else if (take) begin
        ready <= 1'b0;
      end
    end
  end

  // R4
  ready_not_busy_chk: assert property (@(posedge clk) disable iff (rst) ready |-> !busy);
  // R4
  ready_after_conv_chk: assert property (@(posedge clk) disable iff (rst) $rose(ready) |-> $past(busy));
endmodule

// File: rtl/rht_i2c_target.sv
module rht_i2c_target import rht_pkg::*; #(
  parameter int         CONV_CYCLES = 3000,
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] BASE_ADDR   = 7'h44,
  parameter logic [7:0] CMD_HI      = 8'h2C,
  parameter logic [7:0] CMD_LO      = 8'h06
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pull_o,
  input  logic              addr_sel_i,
  input  logic [WORD_W-1:0] temp_i,
  input  logic [WORD_W-1:0] humi_i
);
  localparam logic [2:0] LAST_BYTE = 3'd5;

  logic scl_q, sda_q, scl_rise, scl_fall, bus_start, bus_stop;
  logic res_ready, conv_done, conv_kick, rd_take, addr_match;
  tgt_state_t st;
  logic [3:0] bitcnt;
  logic [7:0] shreg, cmd_first, first_tx, next_tx;
  logic [2:0] bidx;
  logic cmd_hit, ack_seen, is_rd, drv_q;
  logic [WORD_W-1:0] t_snap, h_snap;

  rht_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_q(scl_q), .sda_q(sda_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .bus_start(bus_start), .bus_stop(bus_stop)
  );

  rht_conv_timer #(.CONV_CYCLES(CONV_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .kick(conv_kick), .take(rd_take),
    .ready(res_ready), .done(conv_done)
  );

  function automatic logic [7:0] pick(input logic [2:0] i,
                                      input logic [WORD_W-1:0] t, h);
    case (i)
      3'd0:    return t[15:8];
      3'd1:    return t[7:0];
      3'd2:    return crc8_word(t);
      3'd3:    return h[15:8];
      3'd4:    return h[7:0];
      default: return crc8_word(h);
    endcase
  endfunction

  assign first_tx   = pick(3'd0, t_snap, h_snap);
  assign next_tx    = pick(bidx + 3'd1, t_snap, h_snap);
  assign addr_match = (shreg[7:1] == {BASE_ADDR[6:1], addr_sel_i});
  assign conv_kick  = bus_stop & cmd_hit;
  assign rd_take    = !bus_start && !bus_stop && st == ST_ADDR && scl_fall &&
                      bitcnt == 4'd8 && addr_match && shreg[0] && res_ready;
  assign sda_pull_o = drv_q;

  // measurement snapshot taken when the conversion completes
  always_ff @(posedge clk) begin
    if (rst) begin
      t_snap <= '0;
      h_snap <= '0;
    end else if (conv_done) begin
      t_snap <= temp_i;
      h_snap <= humi_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE; bitcnt <= '0; shreg <= '0; bidx <= '0;
      cmd_first <= '0; cmd_hit <= 1'b0; ack_seen <= 1'b0;
      is_rd <= 1'b0; drv_q <= 1'b0;
    end else if (bus_start) begin
      st <= ST_ADDR; bitcnt <= '0; drv_q <= 1'b0; cmd_hit <= 1'b0;
    end else if (bus_stop) begin
      st <= ST_IDLE; drv_q <= 1'b0; cmd_hit <= 1'b0;
    end else begin
      case (st)
        ST_ADDR, ST_RX: begin
          if (scl_rise && bitcnt < 4'd8) begin
            shreg  <= {shreg[6:0], sda_q};
            bitcnt <= bitcnt + 4'd1;
          end else if (scl_fall && bitcnt == 4'd8) begin
            if (st == ST_ADDR) begin
              if (addr_match && (!shreg[0] || res_ready)) begin
                drv_q <= 1'b1;
                is_rd <= shreg[0];
                st    <= ST_AACK;
              end else begin
                st <= ST_HOLD;
              end
            end else begin
              drv_q <= 1'b1;
              st    <= ST_WACK;
              if (bidx == 3'd0) cmd_first <= shreg;
              cmd_hit <= (bidx == 3'd1) && (cmd_first == CMD_HI) && (shreg == CMD_LO);
            end
          end
        end
        ST_AACK: if (scl_fall) begin
          bidx <= '0;
          if (is_rd) begin
            drv_q  <= ~first_tx[7];
            shreg  <= {first_tx[6:0], 1'b0};
            bitcnt <= 4'd1;
            st     <= ST_TX;
          end else begin
            drv_q  <= 1'b0;
            bitcnt <= '0;
            st     <= ST_RX;
          end
        end
        ST_WACK: if (scl_fall) begin
          drv_q  <= 1'b0;
          bitcnt <= '0;
          st     <= ST_RX;
          if (bidx != 3'd7) bidx <= bidx + 3'd1;
        end
        ST_TX: if (scl_fall) begin
          if (bitcnt == 4'd8) begin
            drv_q <= 1'b0;
            st    <= ST_MACK;
          end else begin
            drv_q  <= ~shreg[7];
            shreg  <= {shreg[6:0], 1'b0};
            bitcnt <= bitcnt + 4'd1;
          end
        end
        ST_MACK: begin
          if (scl_rise) ack_seen <= ~sda_q;
          else if (scl_fall) begin
            if (ack_seen && bidx != LAST_BYTE) begin
              bidx   <= bidx + 3'd1;
              drv_q  <= ~next_tx[7];
              shreg  <= {next_tx[6:0], 1'b0};
              bitcnt <= 4'd1;
              st     <= ST_TX;
            end else begin
              st <= ST_HOLD;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // R10
  pull_scl_low_chk: assert property (@(posedge clk) disable iff (rst) !$stable(drv_q) |-> !scl_q);
  // R8
  hdr_ack_ready_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(drv_q) && st == ST_AACK && is_rd) |-> $past(res_ready));
  // R1
  idle_released_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE || st == ST_HOLD) |-> !drv_q);
  // R5
  byte_index_chk: assert property (@(posedge clk) disable iff (rst) st == ST_TX |-> bidx <= LAST_BYTE);
endmodule

// File: tb/sim_rht_i2c_target.sv
`timescale 1ns/1ps
module sim_rht_i2c_target;
  localparam int CONV = 1000;
  localparam int Q    = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1, addr_sel = 1'b0;
  logic [15:0] temp = '0, humi = '0;
  logic sda_pull, sda_line;
  int n_tests = 0, n_fail = 0, r10_viol = 0;
  logic [7:0] rb [0:5];
  logic hdr_ok;
  logic [2:0] wacks;
  logic prev_pull = 1'b0;

  localparam logic [31:0] VECS [4] = '{32'h6A3C_5E12, 32'h0000_0000,
                                       32'hFFFF_FFFF, 32'h1234_BEEF};

  always #2 clk = ~clk;
  assign sda_line = sda_m & ~sda_pull;

  rht_i2c_target #(.CONV_CYCLES(CONV)) u0 (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_pull_o(sda_pull),
    .addr_sel_i(addr_sel), .temp_i(temp), .humi_i(humi)
  );

  // R10 monitor: pull level must not move while the master holds SCL high
  always @(negedge clk) begin
    if (!rst && scl_m && sda_pull != prev_pull) r10_viol++;
    prev_pull <= sda_pull;
  end

  function automatic logic [7:0] ref_crc(input logic [15:0] w);
    logic [7:0] r;
    r = 8'hFF;
    for (int b = 0; b < 2; b++) begin
      r = r ^ ((b == 0) ? w[15:8] : w[7:0]);
      for (int k = 0; k < 8; k++) r = r[7] ? ({r[6:0], 1'b0} ^ 8'h31) : {r[6:0], 1'b0};
    end
    return r;
  endfunction

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clk_bit(input logic b, output logic s);
    sda_m = b; tick(Q); scl_m = 1'b1; tick(Q); s = sda_line; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(2*Q); sda_m = 1'b0; tick(2*Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(2*Q); sda_m = 1'b1; tick(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic recv_byte(input logic nack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin clk_bit(1'b1, s); d[i] = s; end
    clk_bit(nack, s);
  endtask

  task automatic do_cmd(input logic [6:0] a, input logic [7:0] c1, input logic [7:0] c0);
    logic k;
    i2c_start();
    send_byte({a, 1'b0}, k); wacks[0] = k;
    send_byte(c1, k);        wacks[1] = k;
    send_byte(c0, k);        wacks[2] = k;
    i2c_stop();
  endtask

  // reads n bytes, NACKs the last; leaves the bus low-SCL when keep_open is set
  task automatic do_read(input logic [6:0] a, input int n, input logic keep_open);
    logic k;
    logic [7:0] d;
    i2c_start();
    send_byte({a, 1'b1}, k);
    hdr_ok = k;
    for (int i = 0; i < 6; i++) rb[i] = 8'hxx;
    for (int i = 0; i < n; i++) begin recv_byte(i == n - 1, d); rb[i] = d; end
    if (!keep_open) i2c_stop();
  endtask

  task automatic full_read_check(input string tag, input logic [15:0] t, input logic [15:0] h);
    do_read(7'h44, 6, 1'b0);
    chk({tag, " hdr ACK (R4)"}, hdr_ok, 1);
    chk({tag, " temp hi (R5)"}, rb[0], t[15:8]);
    chk({tag, " temp lo (R5)"}, rb[1], t[7:0]);
    chk({tag, " temp crc (R6)"}, rb[2], ref_crc(t));
    chk({tag, " humi hi (R5)"}, rb[3], h[15:8]);
    chk({tag, " humi lo (R5)"}, rb[4], h[7:0]);
    chk({tag, " humi crc (R6)"}, rb[5], ref_crc(h));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic s;
    tick(5); rst = 1'b0; tick(3);
    // R11: released after reset, nothing pending
    chk("R11 sda released", sda_pull, 0);
    do_read(7'h44, 1, 1'b0);
    chk("R11 no pending result", hdr_ok, 0);

    // vector table: R2 R5 R6
    for (int v = 0; v < 4; v++) begin
      temp = VECS[v][31:16]; humi = VECS[v][15:0];
      do_cmd(7'h44, 8'h2C, 8'h06);
      chk("R2 command acks", {29'd0, wacks}, 32'd7);
      tick(CONV + 50);
      full_read_check("vec", VECS[v][31:16], VECS[v][15:0]);
    end

    // R6 known value
    temp = 16'hBEEF; humi = 16'hBEEF;
    do_cmd(7'h44, 8'h2C, 8'h06); tick(CONV + 50);
    do_read(7'h44, 6, 1'b0);
    chk("R6 crc of BEEF (temp)", rb[2], 8'h92);
    chk("R6 crc of BEEF (humi)", rb[5], 8'h92);

    // R8: consumed result, second read NACKed
    do_read(7'h44, 2, 1'b0);
    chk("R8 second read nacked", hdr_ok, 0);
    chk("R8 bus released data", rb[0], 8'hFF);

    // R4: early read NACK then ACK
    temp = 16'h0A0B; humi = 16'h0C0D;
    do_cmd(7'h44, 8'h2C, 8'h06); tick(20);
    do_read(7'h44, 1, 1'b0);
    chk("R4 early read nacked", hdr_ok, 0);
    tick(CONV + 50);
    full_read_check("R4 late", 16'h0A0B, 16'h0C0D);

    // R3: wrong command acked, no measurement
    do_cmd(7'h44, 8'h2C, 8'h07);
    chk("R3 bad command acks", {29'd0, wacks}, 32'd7);
    tick(CONV + 50);
    do_read(7'h44, 1, 1'b0);
    chk("R3 no measurement", hdr_ok, 0);

    // R1: strap selects 0x45
    addr_sel = 1'b1;
    do_cmd(7'h44, 8'h2C, 8'h06);
    chk("R1 0x44 ignored when strap high", {29'd0, wacks}, 32'd0);
    temp = 16'h4455; humi = 16'h6677;
    do_cmd(7'h45, 8'h2C, 8'h06);
    chk("R1 0x45 acked", {29'd0, wacks}, 32'd7);
    tick(CONV + 50);
    do_read(7'h44, 2, 1'b0);
    chk("R1 absent addr hdr", hdr_ok, 0);
    chk("R1 absent addr word", {rb[0], rb[1]}, 16'hFFFF);
    do_read(7'h45, 6, 1'b0);
    chk("R1 0x45 read hdr", hdr_ok, 1);
    chk("R1 0x45 temp", {rb[0], rb[1]}, 16'h4455);
    addr_sel = 1'b0;

    // R7: master NACK after temperature low byte
    temp = 16'h7788; humi = 16'h99AA;
    do_cmd(7'h44, 8'h2C, 8'h06); tick(CONV + 50);
    do_read(7'h44, 2, 1'b1);
    chk("R7 temp before nack", {rb[0], rb[1]}, 16'h7788);
    for (int i = 0; i < 9; i++) begin
      clk_bit(1'b1, s);
      chk("R7 sda released after nack", s, 1);
    end
    i2c_stop();
    do_cmd(7'h44, 8'h2C, 8'h06);
    chk("R7 next frame acked", {29'd0, wacks}, 32'd7);

    // R9: input change after conversion does not alter result
    temp = 16'h1111; humi = 16'h2222;
    do_cmd(7'h44, 8'h2C, 8'h06); tick(CONV + 50);
    temp = 16'h3333; humi = 16'h4444;
    full_read_check("R9 snapshot", 16'h1111, 16'h2222);

    // R12: long gap
    temp = 16'h5A5A; humi = 16'hA5A5;
    do_cmd(7'h44, 8'h2C, 8'h06); tick(20000);
    full_read_check("R12 long gap", 16'h5A5A, 16'hA5A5);

    chk("R10 sda moved while SCL high", r10_viol, 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule